// File: doc/BRIEF.md
# Smartcard Inactivity Wait Timers

This block watches a smartcard link for silence with three independent timers: a work timer, a block timer and a character timer. Each timer counts clock cycles since its most recent restart event and compares that count against a limit supplied on its own input. When the limit is reached, the timer's interrupt flag is set. A combined interrupt line carries the OR of the three flags, each gated by its own enable bit.

The flags follow the timeout condition, not a one-shot event. A counter stops at its limit instead of wrapping, so the timeout persists until the timer is restarted. If software clears a flag while the timeout still holds, the flag comes back one cycle later. To keep a flag cleared, software must restart the timer first. A received character restarts the work and character timers. The start of a transmitted block restarts the block timer.

The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `sc_wait_timers`

## Requirements
- R1: With limit L on the work timer, the work flag (flag bit 0) is low for the first L rising edges after the edge that samples a received-character restart, and high from edge L+1. This includes L = 0, where the flag sets on the first edge.
- R2: The character timer (flag bit 2) follows the R1 timing with its own limit and is restarted by the same received-character input.
- R3: The block timer (flag bit 1) is restarted only by the transmitted-block-start input, and follows the R1 timing from that restart. Received characters do not restart it.
- R4: A clear strobe for a flag whose timeout still holds drives that flag low at the sampling edge, and the flag is high again at the next edge.
- R5: When a timer is restarted before its flag is cleared, the cleared flag stays low until the full limit has elapsed again. It sets at edge L+1 after the restart edge.
- R6: When a clear and a restart for the same timer arrive in the same cycle, the restart wins: the flag is low after that edge and stays low for L further edges.
- R7: Each counter saturates at its limit and does not wrap. After a wait much longer than the counter range, a cleared flag still reasserts on the next edge.
- R8: The combined interrupt is high exactly when some flag bit i is high together with enable bit i. Bit order is work = 0, block = 1, char = 2.
- R9: A set flag stays high when its timer is restarted, until a clear strobe arrives.
- R10: During reset, and right after reset is released, all flags and the combined interrupt are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lim_work_i | input | CNT_W | Work timer limit in cycles |
| lim_block_i | input | CNT_W | Block timer limit in cycles |
| lim_char_i | input | CNT_W | Character timer limit in cycles |
| rx_char_i | input | 1 | Character received; restarts work and character timers |
| tx_blk_start_i | input | 1 | Transmitted block starts; restarts block timer |
| clr_i | input | 3 | Per-flag clear strobes (work, block, char) |
| en_i | input | 3 | Per-flag enables for the combined interrupt |
| flag_o | output | 3 | Interrupt flags (work, block, char) |
| irq_o | output | 1 | Combined gated interrupt |

## Verification
A restart sampled at one edge clears the counter there. The flag then rises at edge L+1, because the count reaches L after L edges and the flag register adds one edge more. A clear takes effect at the edge that samples it, and a reasserted flag appears one edge after that. The combined interrupt follows the flags and enables with no register in between. The bench drives inputs and samples outputs on falling edges. It counts rising edges from each restart, so it checks the flag in the last cycle before the rise and in the cycle of the rise, for every limit in a small sweep.

// File: rtl/sc_wait_pkg.sv
package sc_wait_pkg;
  localparam int unsigned NUM_TMR = 3;

  typedef enum int unsigned {
    TMR_WORK  = 0,
    TMR_BLOCK = 1,
    TMR_CHAR  = 2
  } tmr_idx_e;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/sc_wait_chan.sv
module sc_wait_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             restart_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             flag_q, flag_d;
  logic             timeout;

  // The count stops once it reaches the limit.
  assign timeout = (cnt_q >= lim_i);

  always_comb begin
    cnt_en = restart_i || !timeout;
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The flag is sticky until cleared. A restart wins over a timeout seen in the same cycle.
  always_comb begin
    if (clr_i) flag_d = 1'b0;
    else       flag_d = flag_q || (timeout && !restart_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_hold_at_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout && !restart_i && $stable(lim_i)) |=> (cnt_q == $past(cnt_q)));

  assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  assert_restart_beats_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && clr_i) |=> !flag_o);

  assert_clear_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);

  assert_reassert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout && !restart_i && !clr_i) |=> flag_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/sc_irq_merge.sv
module sc_irq_merge #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_comb begin
    irq_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      irq_o = irq_o | (flag_i[i] & en_i[i]);
    end
  end
endmodule

// File: rtl/sc_wait_timers.sv
module sc_wait_timers
  import sc_wait_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lim_work_i,
  input  logic [CNT_W-1:0] lim_block_i,
  input  logic [CNT_W-1:0] lim_char_i,
  input  logic             rx_char_i,
  input  logic             tx_blk_start_i,
  input  logic [2:0]       clr_i,
  input  logic [2:0]       en_i,
  output logic [2:0]       flag_o,
  output logic             irq_o
);
  logic               rst_int_n;
  logic [CNT_W-1:0]   lim [NUM_TMR];
  logic [NUM_TMR-1:0] restart;
  logic [NUM_TMR-1:0] flags;

  sc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  always_comb begin
    lim[TMR_WORK]      = lim_work_i;
    lim[TMR_BLOCK]     = lim_block_i;
    lim[TMR_CHAR]      = lim_char_i;
    restart[TMR_WORK]  = rx_char_i;
    restart[TMR_BLOCK] = tx_blk_start_i;
    restart[TMR_CHAR]  = rx_char_i;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
    sc_wait_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_int_n),
      .lim_i     (lim[g]),
      .restart_i (restart[g]),
      .clr_i     (clr_i[g]),
      .flag_o    (flags[g])
    );
  end

  sc_irq_merge #(.N(NUM_TMR)) u_merge (
    .flag_i (flags),
    .en_i   (en_i),
    .irq_o  (irq_o)
  );

  assign flag_o = flags;

  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((flags & en_i) == '0) |-> !irq_o);

  assert_gated_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((flags & en_i) != '0) |-> irq_o);

  always_ff @(posedge clk_i) begin
    if (!rst_int_n) begin
      assert_reset_clear_R10: assert (flag_o == '0 || !rst_ni);
    end
  end
endmodule

// File: tb/sc_wait_timers_bench.sv
module sc_wait_timers_bench;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] lim_w, lim_b, lim_c;
  logic          rx, txs;
  logic [2:0]    clr, en;
  logic [2:0]    flag;
  logic          irq;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;

  sc_wait_timers #(.CNT_W(CW)) u_sc_wait_timers (
    .clk_i(clk), .rst_ni(rst_n),
    .lim_work_i(lim_w), .lim_block_i(lim_b), .lim_char_i(lim_c),
    .rx_char_i(rx), .tx_blk_start_i(txs),
    .clr_i(clr), .en_i(en), .flag_o(flag), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Restart timer idx (with a clear of its flag in the same cycle), then watch the rise.
  task automatic sweep(input int idx, input int L, input string req);
    if (idx == 1) txs = 1'b1; else rx = 1'b1;
    clr[idx] = 1'b1;
    tick();
    rx = 1'b0; txs = 1'b0; clr = '0;
    chk(flag[idx], 1'b0, "R6 restart beats clear");
    for (int k = 1; k <= L + 1; k++) begin
      tick();
      chk(flag[idx], (k >= L + 1), req);
    end
  endtask

  initial begin
    rst_n = 1'b0; rx = 1'b0; txs = 1'b0; clr = '0; en = '0;
    lim_w = '1; lim_b = '1; lim_c = '1;
    repeat (4) tick();
    chk(flag[0] | flag[1] | flag[2], 1'b0, "R10 flags in reset");
    chk(irq, 1'b0, "R10 irq in reset");
    rst_n = 1'b1;
    repeat (3) tick();
    chk(flag[0] | flag[1] | flag[2], 1'b0, "R10 flags after release");
    chk(irq, 1'b0, "R10 irq after release");

    // R1: work timer sweep
    lim_c = '1;
    for (int L = 0; L <= 6; L++) begin
      lim_w = CW'(L);
      sweep(0, L, "R1 work rise timing");
    end
    // R2: character timer sweep
    lim_w = '1;
    for (int L = 0; L <= 6; L++) begin
      lim_c = CW'(L);
      sweep(2, L, "R2 char rise timing");
    end
    // R3: block timer sweep, with received characters that must not restart it
    for (int L = 0; L <= 6; L++) begin
      lim_b = CW'(L);
      txs = 1'b1; clr[1] = 1'b1;
      tick();
      txs = 1'b0; clr = '0; rx = 1'b1;
      for (int k = 1; k <= L + 1; k++) begin
        tick();
        chk(flag[1], (k >= L + 1), "R3 block ignores rx, rise timing");
      end
      rx = 1'b0;
    end

    // R4: clear while the timeout holds, then reassertion (work timer at limit 3)
    lim_w = 4'd3;
    sweep(0, 3, "R1 work rise timing");
    repeat (2) tick();
    clr[0] = 1'b1;
    tick();
    clr = '0;
    chk(flag[0], 1'b0, "R4 drop on clear");
    tick();
    chk(flag[0], 1'b1, "R4 reassert next cycle");

    // R9 then R5: restart alone keeps the flag, then a clear holds until the limit
    lim_w = 4'd4;
    rx = 1'b1;
    tick();
    rx = 1'b0;
    chk(flag[0], 1'b1, "R9 flag sticky across restart");
    clr[0] = 1'b1;
    tick();
    clr = '0;
    chk(flag[0], 1'b0, "R5 cleared after restart");
    for (int k = 2; k <= 5; k++) begin
      tick();
      chk(flag[0], (k >= 5), "R5 stays low until limit");
    end

    // R7: saturation, long wait far past the 4-bit range
    lim_c = 4'd15;
    sweep(2, 15, "R2 char rise timing");
    repeat (40) tick();
    chk(flag[2], 1'b1, "R7 flag held after long wait");
    clr[2] = 1'b1;
    tick();
    clr = '0;
    chk(flag[2], 1'b0, "R7 drop on clear");
    tick();
    chk(flag[2], 1'b1, "R7 no wrap, reassert");

    // R8: only the work flag set, sweep enables
    lim_w = 4'd0; lim_b = 4'd15; lim_c = 4'd15;
    rx = 1'b1; txs = 1'b1; clr = 3'b111;
    tick();
    rx = 1'b0; txs = 1'b0; clr = '0;
    tick();
    for (int e = 0; e < 8; e++) begin
      en = 3'(e);
      #0.5;
      chk(flag[0], 1'b1, "R8 work flag set");
      chk(irq, en[0], "R8 irq gated single flag");
      tick();
    end
    // R8: all flags set, sweep enables
    lim_b = 4'd0; lim_c = 4'd0;
    repeat (2) tick();
    for (int e = 0; e < 8; e++) begin
      en = 3'(e);
      #0.5;
      chk(irq, (e != 0), "R8 irq gated all flags");
      tick();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule